// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is a serial test access port controller of the kind found on devices that sit in an IEEE 1149.1 scan chain. A test clock, a mode-select line and a serial data input drive a sixteen-state controller. Instructions and data are shifted through a small set of internal scan registers: an 8-bit instruction register, a one-bit bypass register and a 32-bit identification register. The controller state is reported as a one-hot vector. The latched instruction is exported so that neighbouring logic can decode it.

Two strobes reach the outside. A test-mode start pulse announces that a program, erase or verify instruction is in force. That pulse is deferred until the controller next arrives in Run-Test/Idle. Every other instruction is announced by an update pulse during the Update-IR or Update-DR state. The reset input is active low and is sampled on the rising test clock. Holding the mode-select line high also returns the controller to its reset state. After that reset, the identification register is selected without any instruction scan.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: While trst_n is low on a rising tck edge, the controller enters Test-Logic-Reset (state_onehot = 16'h0001). In that state instr reads 8'h01, test_start and update_pulse are 0, and after the next falling edge tdo and tdo_en are 0.
- R2: On each rising tck edge the state follows the standard sixteen-state graph, using the value of tms on that edge. The state_onehot bit indices are:
  - 0 Test-Logic-Reset, 1 Run-Test/Idle
  - 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR
  - 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR
- R3: From any state, five consecutive rising edges with tms high leave the controller in Test-Logic-Reset.
- R4: Capture-IR loads the identification opcode 8'h01 into the instruction shift register. The first eight bits shifted out of Shift-IR are therefore 1,0,0,0,0,0,0,0, and the two low bits are 2'b01.
- R5: Opcode 8'h01 selects the 32-bit identification register, with a default value of 32'h1A5C_E0F3 and bit 0 at 1. Capture-DR loads it, and it shifts out LSB first. Entering Test-Logic-Reset selects it without any instruction scan.
- R6: Opcode 8'hFF selects the one-bit bypass register. Capture-DR clears it, so a Shift-DR of n bits presents 0 first and then each tdi bit one shift later.
- R7: Any opcode other than 8'h01, 8'hC0, 8'hC1, 8'hC2 and 8'hFF selects the bypass register, with the same behaviour as R6. The test-mode opcodes 8'hC0, 8'hC1 and 8'hC2 also select bypass.
- R8: When the instruction latched at Update-IR is 8'hC0 (program), 8'hC1 (erase) or 8'hC2 (verify), test_start is 1 for exactly the first tck cycle of the next stay in Run-Test/Idle. This holds even if DR scans come in between. test_start is never 1 in Update-IR or in any other state.
- R9: update_pulse is 1 during Update-DR, and during Update-IR, only when the instruction concerned is not a test-mode opcode. It is 0 in every other state.
- R10: tdo and tdo_en change only on the falling tck edge. tdo_en is 1 only while the state is Shift-DR or Shift-IR. Otherwise tdo is 0.
- R11: instr changes only on the rising edge that leaves Update-IR, when it takes the shifted opcode, or while in Test-Logic-Reset, when it takes 8'h01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low reset, sampled on rising tck |
| tms | input | 1 | Mode select, steers the state graph |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_en | output | 1 | High while tdo carries scan data |
| state_onehot | output | 16 | One-hot controller state, bit order as in R2 |
| instr | output | 8 | Currently latched instruction |
| test_start | output | 1 | One-cycle start strobe for program, erase or verify |
| update_pulse | output | 1 | One-cycle strobe for all other instructions |

## Verification
The bench visits every state and applies both values of tms, so all 32 edges of the graph are checked. A wrong arc would show up as a misplaced one-hot bit. From each state it also holds tms high for five edges, which catches a controller whose reset path needs more edges. The test-mode instructions are checked both with a direct Update-IR to Run-Test/Idle path and with a DR scan in between. A design that fires the start strobe at Update-IR, or loses the pending start across the scan, would miss the expected single pulse. The bench also reads the identification value after Test-Logic-Reset, both with and without a prior bypass load, and pushes patterns through bypass for both the defined and an undecoded opcode. That catches a wrong LSB-first order, a missing capture of 0, or a wrong default selection.

// File: rtl/jtag_tap_pkg.sv
// Package: shared state type, data-register select type and the
// transition function of the sixteen-state test access port graph.
// Assumes one transition per rising test clock edge.
package jtag_tap_pkg;

    localparam int unsigned NUM_STATES = 16;

    typedef enum logic [3:0] {
        ST_RESET    = 4'd0,
        ST_IDLE     = 4'd1,
        ST_DR_SEL   = 4'd2,
        ST_DR_CAP   = 4'd3,
        ST_DR_SHIFT = 4'd4,
        ST_DR_EXIT1 = 4'd5,
        ST_DR_PAUSE = 4'd6,
        ST_DR_EXIT2 = 4'd7,
        ST_DR_UPD   = 4'd8,
        ST_IR_SEL   = 4'd9,
        ST_IR_CAP   = 4'd10,
        ST_IR_SHIFT = 4'd11,
        ST_IR_EXIT1 = 4'd12,
        ST_IR_PAUSE = 4'd13,
        ST_IR_EXIT2 = 4'd14,
        ST_IR_UPD   = 4'd15
    } tap_state_e;

    typedef enum logic {
        DR_PICK_BYPASS = 1'b0,
        DR_PICK_IDENT  = 1'b1
    } dr_pick_e;

    // Next state for a given current state and sampled mode-select bit.
    function automatic tap_state_e tap_step(input tap_state_e cur, input logic m);
        tap_state_e nxt;
        case (cur)
            ST_RESET:    nxt = m ? ST_RESET    : ST_IDLE;
            ST_IDLE:     nxt = m ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   nxt = m ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   nxt = m ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: nxt = m ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: nxt = m ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: nxt = m ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: nxt = m ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   nxt = m ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   nxt = m ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   nxt = m ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: nxt = m ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: nxt = m ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: nxt = m ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: nxt = m ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   nxt = m ? ST_DR_SEL   : ST_IDLE;
            default:     nxt = ST_RESET;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
// Module: tap_fsm
// Holds the controller state and advances it once per rising tck edge.
// It also expands the state into a one-hot vector.
// Assumes trst_n is synchronous to tck and active low.
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic                  tck,
    input  logic                  trst_n,
    input  logic                  tms,
    output tap_state_e            state,
    output logic [NUM_STATES-1:0] state_onehot
);

    tap_state_e state_q;

    // State register: reset to Test-Logic-Reset, else follow the graph.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= tap_step(state_q, tms);
        end
    end

    assign state = state_q;

    // One decoder bit per state.
    for (genvar gi = 0; gi < NUM_STATES; gi++) begin : g_onehot
        assign state_onehot[gi] = (state_q == tap_state_e'(gi));
    end

endmodule

// File: rtl/tap_ir.sv
// Module: tap_ir
// Instruction shift register, latched instruction, opcode decode and
// the two outward strobes. Capture-IR loads the identification opcode.
// Test-mode opcodes arm a start request that fires on the next stay in
// Run-Test/Idle. Assumes OP_IDCODE has 2'b01 in its two low bits.
module tap_ir
    import jtag_tap_pkg::*;
#(
    parameter int unsigned IR_W       = 8,
    parameter logic [IR_W-1:0] OP_IDCODE  = 8'h01,
    parameter logic [IR_W-1:0] OP_PROGRAM = 8'hC0,
    parameter logic [IR_W-1:0] OP_ERASE   = 8'hC1,
    parameter logic [IR_W-1:0] OP_VERIFY  = 8'hC2,
    parameter logic [IR_W-1:0] OP_BYPASS  = 8'hFF
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic            ir_lsb,
    output logic [IR_W-1:0] instr,
    output dr_pick_e        dr_pick,
    output logic            test_start,
    output logic            update_pulse
);

    logic [IR_W-1:0] ir_shift_q;
    logic [IR_W-1:0] instr_q;
    logic            start_armed_q;
    logic            shifted_is_test;
    logic            latched_is_test;

    // True when an opcode belongs to the deferred test-mode group.
    function automatic logic is_test_op(input logic [IR_W-1:0] op);
        return (op == OP_PROGRAM) || (op == OP_ERASE) || (op == OP_VERIFY);
    endfunction

    assign shifted_is_test = is_test_op(ir_shift_q);
    assign latched_is_test = is_test_op(instr_q);

    // Instruction shift path: capture the ID opcode, then shift LSB first.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            ir_shift_q <= OP_IDCODE;
        end else if (state == ST_IR_CAP) begin
            ir_shift_q <= OP_IDCODE;
        end else if (state == ST_IR_SHIFT) begin
            ir_shift_q <= {tdi, ir_shift_q[IR_W-1:1]};
        end
    end

    // Latched instruction: ID opcode in reset, shifted opcode at Update-IR.
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_RESET) begin
            instr_q <= OP_IDCODE;
        end else if (state == ST_IR_UPD) begin
            instr_q <= ir_shift_q;
        end
    end

    // Start request: armed by a test opcode at Update-IR, spent in Idle.
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_RESET) begin
            start_armed_q <= 1'b0;
        end else if (state == ST_IR_UPD) begin
            start_armed_q <= shifted_is_test;
        end else if (state == ST_IDLE) begin
            start_armed_q <= 1'b0;
        end
    end

    // Data register choice from the latched opcode.
    always_comb begin
        case (instr_q)
            OP_IDCODE: dr_pick = DR_PICK_IDENT;
            OP_BYPASS: dr_pick = DR_PICK_BYPASS;
            default:   dr_pick = DR_PICK_BYPASS;
        endcase
    end

    // Update strobe for non-test instructions in either update state.
    always_comb begin
        case (state)
            ST_IR_UPD: update_pulse = !shifted_is_test;
            ST_DR_UPD: update_pulse = !latched_is_test;
            default:   update_pulse = 1'b0;
        endcase
    end

    assign test_start = (state == ST_IDLE) && start_armed_q;
    assign ir_lsb     = ir_shift_q[0];
    assign instr      = instr_q;

endmodule

// File: rtl/tap_dr.sv
// Module: tap_dr
// Data-register side: a one-bit bypass stage and the identification
// register. Both capture in Capture-DR and shift in Shift-DR. Only the
// register named by dr_pick is shifted and presented.
// Assumes bit 0 of ID_VALUE is 1.
module tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int unsigned     ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_E0F3
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e state,
    input  dr_pick_e   dr_pick,
    output logic       dr_lsb
);

    logic [ID_W-1:0] id_shift_q;
    logic            bypass_q;

    // Identification register: parallel load on capture, shift otherwise.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            id_shift_q <= ID_VALUE;
        end else if (dr_pick == DR_PICK_IDENT) begin
            if (state == ST_DR_CAP) begin
                id_shift_q <= ID_VALUE;
            end else if (state == ST_DR_SHIFT) begin
                id_shift_q <= {tdi, id_shift_q[ID_W-1:1]};
            end
        end
    end

    // Bypass stage: cleared on capture, one-bit delay while shifting.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            bypass_q <= 1'b0;
        end else if (dr_pick == DR_PICK_BYPASS) begin
            if (state == ST_DR_CAP) begin
                bypass_q <= 1'b0;
            end else if (state == ST_DR_SHIFT) begin
                bypass_q <= tdi;
            end
        end
    end

    assign dr_lsb = (dr_pick == DR_PICK_IDENT) ? id_shift_q[0] : bypass_q;

endmodule

// File: rtl/jtag_tap_ctrl.sv
// Module: jtag_tap_ctrl (top)
// Test access port controller with instruction decode. It ties the state
// machine to the instruction and data register sides, and retimes the
// serial output to the falling tck edge.
// Assumes a free-running or gated tck and a reset synchronous to tck.
module jtag_tap_ctrl
    import jtag_tap_pkg::*;
#(
    parameter int unsigned     IR_W       = 8,
    parameter int unsigned     ID_W       = 32,
    parameter logic [ID_W-1:0] ID_VALUE   = 32'h1A5C_E0F3,
    parameter logic [IR_W-1:0] OP_IDCODE  = 8'h01,
    parameter logic [IR_W-1:0] OP_PROGRAM = 8'hC0,
    parameter logic [IR_W-1:0] OP_ERASE   = 8'hC1,
    parameter logic [IR_W-1:0] OP_VERIFY  = 8'hC2,
    parameter logic [IR_W-1:0] OP_BYPASS  = 8'hFF
) (
    input  logic                  tck,
    input  logic                  trst_n,
    input  logic                  tms,
    input  logic                  tdi,
    output logic                  tdo,
    output logic                  tdo_en,
    output logic [NUM_STATES-1:0] state_onehot,
    output logic [IR_W-1:0]       instr,
    output logic                  test_start,
    output logic                  update_pulse
);

    tap_state_e state;
    dr_pick_e   dr_pick;
    logic       ir_lsb;
    logic       dr_lsb;
    logic       tdo_q;
    logic       tdo_en_q;

    tap_fsm u_fsm (
        .tck          (tck),
        .trst_n       (trst_n),
        .tms          (tms),
        .state        (state),
        .state_onehot (state_onehot)
    );

    tap_ir #(
        .IR_W       (IR_W),
        .OP_IDCODE  (OP_IDCODE),
        .OP_PROGRAM (OP_PROGRAM),
        .OP_ERASE   (OP_ERASE),
        .OP_VERIFY  (OP_VERIFY),
        .OP_BYPASS  (OP_BYPASS)
    ) u_ir (
        .tck          (tck),
        .trst_n       (trst_n),
        .tdi          (tdi),
        .state        (state),
        .ir_lsb       (ir_lsb),
        .instr        (instr),
        .dr_pick      (dr_pick),
        .test_start   (test_start),
        .update_pulse (update_pulse)
    );

    tap_dr #(
        .ID_W     (ID_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .state   (state),
        .dr_pick (dr_pick),
        .dr_lsb  (dr_lsb)
    );

    // Output retiming: present serial data on the falling edge, shift states only.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo_q    <= 1'b0;
            tdo_en_q <= 1'b0;
        end else begin
            tdo_en_q <= (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);
            tdo_q    <= (state == ST_IR_SHIFT) ? ir_lsb :
                        (state == ST_DR_SHIFT) ? dr_lsb : 1'b0;
        end
    end

    assign tdo    = tdo_q;
    assign tdo_en = tdo_en_q;

endmodule

// File: rtl/jtag_tap_ctrl_sva.sv
// Module: jtag_tap_ctrl_sva
// Checker bound to the top. It watches the port-level rules on strobes,
// state and serial output. Assumes sampling on the rising tck edge.
module jtag_tap_ctrl_sva (
    input logic        tck,
    input logic        trst_n,
    input logic        tms,
    input logic        tdo,
    input logic        tdo_en,
    input logic [15:0] state_onehot,
    input logic [7:0]  instr,
    input logic        test_start,
    input logic        update_pulse
);

    logic [2:0] high_run;

    // Count consecutive rising edges with tms high, saturating at five.
    always_ff @(posedge tck) begin
        if (!trst_n || !tms) begin
            high_run <= 3'd0;
        end else if (high_run != 3'd5) begin
            high_run <= high_run + 3'd1;
        end
    end

    a_r2_single_state: assert property (@(posedge tck) disable iff (!trst_n)
        $countones(state_onehot) == 1);

    a_r2_reset_exit: assert property (@(posedge tck) disable iff (!trst_n)
        (state_onehot[0] && !tms) |=> state_onehot[1]);

    a_r3_five_high: assert property (@(posedge tck) disable iff (!trst_n)
        (high_run == 3'd5) |-> state_onehot[0]);

    a_r8_start_in_idle: assert property (@(posedge tck) disable iff (!trst_n)
        test_start |-> state_onehot[1]);

    a_r8_start_single: assert property (@(posedge tck) disable iff (!trst_n)
        test_start |=> !test_start);

    a_r9_update_place: assert property (@(posedge tck) disable iff (!trst_n)
        update_pulse |-> (state_onehot[8] || state_onehot[15]));

    a_r10_quiet_tdo: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_en |-> !tdo);

    a_r10_en_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state_onehot[4] || state_onehot[11]));

    a_r11_instr_change: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(instr) |-> ($past(state_onehot[15]) || $past(state_onehot[0])));

endmodule

bind jtag_tap_ctrl jtag_tap_ctrl_sva u_sva (
    .tck          (tck),
    .trst_n       (trst_n),
    .tms          (tms),
    .tdo          (tdo),
    .tdo_en       (tdo_en),
    .state_onehot (state_onehot),
    .instr        (instr),
    .test_start   (test_start),
    .update_pulse (update_pulse)
);

// File: tb/jtag_tap_ctrl_tb.sv
`timescale 1ns/1ps
module jtag_tap_ctrl_tb;

    localparam logic [31:0] ID_VAL  = 32'h1A5C_E0F3;
    localparam logic [7:0]  OP_ID   = 8'h01;
    localparam logic [7:0]  OP_BYP  = 8'hFF;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        tdo;
    logic        tdo_en;
    logic [15:0] state_onehot;
    logic [7:0]  instr;
    logic        test_start;
    logic        update_pulse;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 tck = ~tck;

    jtag_tap_ctrl #(.ID_VALUE(ID_VAL)) u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_en(tdo_en), .state_onehot(state_onehot),
        .instr(instr), .test_start(test_start), .update_pulse(update_pulse)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Standard graph as stated in R2, indices per R2.
    function automatic int nxt(input int s, input bit m);
        case (s)
            0: return m ? 0 : 1;
            1: return m ? 2 : 1;
            2: return m ? 9 : 3;
            3: return m ? 5 : 4;
            4: return m ? 5 : 4;
            5: return m ? 8 : 6;
            6: return m ? 7 : 6;
            7: return m ? 8 : 4;
            8: return m ? 2 : 1;
            9: return m ? 0 : 10;
            10: return m ? 12 : 11;
            11: return m ? 12 : 11;
            12: return m ? 15 : 13;
            13: return m ? 14 : 13;
            14: return m ? 15 : 11;
            default: return m ? 2 : 1;
        endcase
    endfunction

    function automatic string path_to(input int s);
        case (s)
            0: return "";
            1: return "0";
            2: return "01";
            3: return "010";
            4: return "0100";
            5: return "0101";
            6: return "01010";
            7: return "010101";
            8: return "01011";
            9: return "011";
            10: return "0110";
            11: return "01100";
            12: return "01101";
            13: return "011010";
            14: return "0110101";
            default: return "011011";
        endcase
    endfunction

    // One tck cycle: observe tdo after the falling edge, drive, pass the rising edge.
    task automatic step(input logic m, input logic d, output logic so, output logic se);
        @(negedge tck); #1;
        so = tdo; se = tdo_en;
        tms = m; tdi = d;
        @(posedge tck); #1;
    endtask

    task automatic go_reset();
        logic so, se;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, so, se);
    endtask

    task automatic walk(input int s);
        string p;
        logic so, se;
        p = path_to(s);
        for (int i = 0; i < p.len(); i++) step(p[i] == "1", 1'b0, so, se);
    endtask

    // From Run-Test/Idle to Update-IR, shifting op; returns captured bits.
    task automatic load_ir(input logic [7:0] op, output logic [7:0] cap);
        logic so, se;
        step(1, 0, so, se); step(1, 0, so, se); step(0, 0, so, se); step(0, 0, so, se);
        for (int i = 0; i < 8; i++) begin
            step(i == 7, op[i], so, se);
            cap[i] = so;
        end
        step(1, 0, so, se);
    endtask

    // From Run-Test/Idle to Update-DR, shifting n bits.
    task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
        logic so, se;
        dout = '0;
        step(1, 0, so, se); step(0, 0, so, se); step(0, 0, so, se);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], so, se);
            dout[i] = so;
        end
        step(1, 0, so, se);
    endtask

    initial begin
        repeat (150000) @(posedge tck);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic so, se;
        logic [7:0] cap;
        logic [31:0] dout;
        logic [7:0] tst_ops [3];
        tst_ops[0] = 8'hC0; tst_ops[1] = 8'hC1; tst_ops[2] = 8'hC2;

        repeat (4) @(posedge tck);
        #1;
        // R1: reset state
        check(state_onehot == 16'h0001, "R1 state", state_onehot, 16'h0001);
        check(instr == OP_ID, "R1 instr", instr, OP_ID);
        check(!test_start && !update_pulse, "R1 strobes", {test_start, update_pulse}, 0);
        check(!tdo && !tdo_en, "R1 tdo", {tdo, tdo_en}, 0);
        @(negedge tck); #1; trst_n = 1'b1;
        @(posedge tck); #1;

        // R2 and R10: every arc of the graph, with output enable per state
        for (int s = 0; s < 16; s++) begin
            for (int t = 0; t < 2; t++) begin
                go_reset();
                walk(s);
                check(state_onehot == (16'h1 << s), "R2 walk", state_onehot, 16'h1 << s);
                step(t[0], 1'b0, so, se);
                check(se == (s == 4 || s == 11), "R10 tdo_en", se, (s == 4 || s == 11));
                check(se || !so, "R10 tdo idle", so, 0);
                check(state_onehot == (16'h1 << nxt(s, t[0])), "R2 arc", state_onehot, 16'h1 << nxt(s, t[0]));
            end
        end

        // R3: five high edges from every state
        for (int s = 0; s < 16; s++) begin
            go_reset();
            walk(s);
            go_reset();
            check(state_onehot == 16'h0001, "R3 five", state_onehot, 16'h0001);
        end

        // R5: identification read with no instruction load
        go_reset(); step(0, 0, so, se);
        scan_dr(32, 32'h0, dout);
        check(dout == ID_VAL && dout[0], "R5 id read", dout, ID_VAL);
        check(update_pulse == 1'b1, "R9 update dr", update_pulse, 1);
        step(0, 0, so, se);

        // R4, R6, R9, R11: load bypass
        load_ir(OP_BYP, cap);
        check(cap == 8'h01, "R4 capture", cap, 8'h01);
        check(update_pulse && !test_start, "R9 update ir", {update_pulse, test_start}, 2'b10);
        check(instr == OP_ID, "R11 hold before update", instr, OP_ID);
        step(0, 0, so, se);
        check(instr == OP_BYP && !test_start, "R11 latch", instr, OP_BYP);
        scan_dr(9, 32'h1B5, dout);
        check(dout[8:0] == {8'hB5, 1'b0}, "R6 bypass", dout, {8'hB5, 1'b0});
        check(update_pulse == 1'b1, "R9 update dr byp", update_pulse, 1);
        step(0, 0, so, se);

        // R7: undecoded opcode behaves as bypass
        load_ir(8'h5A, cap);
        step(0, 0, so, se);
        scan_dr(9, 32'h0CA, dout);
        check(dout[8:0] == {8'hCA, 1'b0}, "R7 undecoded", dout, {8'hCA, 1'b0});
        step(0, 0, so, se);

        // R8: test-mode opcodes fire start on entry to idle, not at update
        foreach (tst_ops[k]) begin
            load_ir(tst_ops[k], cap);
            check(!update_pulse && !test_start, "R8 none at update-ir", {update_pulse, test_start}, 0);
            step(0, 0, so, se);
            check(test_start == 1'b1, "R8 start", test_start, 1);
            check(instr == tst_ops[k], "R11 test instr", instr, tst_ops[k]);
            step(0, 0, so, se);
            check(test_start == 1'b0, "R8 single", test_start, 0);
        end

        // R8 deferred across a DR scan; R9 no DR update for a test opcode
        load_ir(8'hC1, cap);
        step(1, 0, so, se); step(0, 0, so, se); step(1, 0, so, se); step(1, 0, so, se);
        check(!update_pulse && !test_start, "R9 no update for test", {update_pulse, test_start}, 0);
        step(0, 0, so, se);
        check(test_start == 1'b1, "R8 deferred start", test_start, 1);
        step(0, 0, so, se);

        // R5 and R11: reset reselects the identification register
        load_ir(OP_BYP, cap); step(0, 0, so, se);
        go_reset();
        check(instr == OP_ID, "R11 reset instr", instr, OP_ID);
        step(0, 0, so, se);
        scan_dr(32, 32'hFFFF_FFFF, dout);
        check(dout == ID_VAL, "R5 id after reset", dout, ID_VAL);
        step(0, 0, so, se);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule